// File: doc/BRIEF.md
# Single-Cycle Harvard 16-bit Processor Core

This block is a non-pipelined processor core that completes one 16-bit instruction on every clock edge. Instructions are fetched from a separate instruction memory through a combinational read port addressed by the program counter. Loads and stores use a second memory port that has its own address, write data, write enable and read data. Inside the core are the program counter, a bank of four 16-bit general registers, a three-bit condition flag register, the instruction decoder, the arithmetic unit, and a two-state run/halt controller.

An instruction word holds a 4-bit opcode in bits [15:12], a destination register index in bits [11:10], a source register index in bits [9:8] and an 8-bit immediate in bits [7:0]. When the immediate field is 0xFF, arithmetic and jump instructions take a register operand in place of the immediate. Register indices are 0 to 3. Conditional jumps do not compare registers. They test the flags left by the most recent arithmetic instruction. The controller has two states. `ST_RUN` executes instructions. `ST_HALT` is entered through the transition *halt_seen*, taken at the clock edge of a HALT instruction. The only way out of `ST_HALT` is the transition *reset_exit*, caused by reset. While halted, the core takes the *hold* self-transition on every cycle.

Top module: `hv16_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all four registers and all three flags (zero, negative, positive), and returns the controller to `ST_RUN`, so `halted` reads 0. Right after reset, no conditional jump is taken.
- R2: When no jump is taken and no HALT is executed, the program counter advances by exactly 1 per clock.
- R3: Opcodes 0 to 5 compute the following into the destination register: OR 0, NOT 1 (bitwise invert of the destination; the operand is ignored), AND 2, XOR 3, ADD 4, SUB 5 (destination minus operand, modulo 2^16). The operand is the source register when bits [7:0] equal 0xFF; otherwise it is the immediate, zero-extended.
- R4: MULT (opcode 6) keeps the low 16 bits of the product. DIV (opcode 7) is an unsigned quotient, and division by zero yields 0xFFFF.
- R5: Only opcodes 0 to 7 update the flags. Zero is set when the result is 0, negative is set from result bit 15, and positive is set when the result is neither zero nor negative. All other opcodes leave the flags unchanged.
- R6: JMPZ (12), JMPN (13) and JMPP (14) jump when the zero, negative or positive flag respectively is set. The target is the destination register's value when bits [7:0] equal 0xFF, and the zero-extended immediate otherwise. A jump that is not taken advances the program counter by 1.
- R7: MOV (8) copies the source register into the destination register, and MOVI (9) loads the zero-extended immediate.
- R8: LOAD (10) writes data memory at the source register's address into the destination register. STORE (11) asserts the write enable for one cycle, with the address taken from the destination register and the data from the source register. The write enable is never asserted for any other instruction.
- R9: HALT (15) freezes the program counter on the HALT word and asserts `halted` from the next cycle until reset. While halted, no register, flag or memory write occurs.
- R10: A loop that subtracts 1 from a counter and then jumps back while the positive flag is set runs once per count and falls through when the counter reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W (16) | Program counter, used as the instruction memory address |
| imem_data | input | 16 | Instruction word read combinationally at `imem_addr` |
| dmem_addr | output | DW (16) | Data memory address for load or store |
| dmem_wdata | output | DW (16) | Data memory write data |
| dmem_we | output | 1 | Data memory write enable, one cycle per store |
| dmem_rdata | input | DW (16) | Data memory read data, combinational at `dmem_addr` |
| halted | output | 1 | High while the controller is in `ST_HALT` |

## Verification
The bench runs four programs. Each program isolates a different part of the instruction behaviour. An arithmetic program alternates the register and immediate operand forms across all eight arithmetic opcodes, including division by zero, so a wrong operand select or a wrong result shows up as a wrong stored word. A countdown loop that copies values through memory exercises the backward jump on the positive flag, load-after-store ordering and the loop exit at zero. A flag program places moves, loads and stores between the flag-setting subtraction and the jump, which separates flags held correctly from flags rewritten by non-arithmetic instructions, and it uses both immediate and register jump targets. A final program runs jumps directly after reset to show that the flags start cleared.

// File: rtl/hv16_pkg.sv
package hv16_pkg;

    localparam int INSTR_W   = 16;
    localparam int IMM_W     = 8;
    localparam int RFIELD_W  = 2;
    localparam logic [IMM_W-1:0] REG_FORM_MARK = 8'hFF;

    typedef enum logic [3:0] {
        OP_OR    = 4'd0,
        OP_NOT   = 4'd1,
        OP_AND   = 4'd2,
        OP_XOR   = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_MUL   = 4'd6,
        OP_DIV   = 4'd7,
        OP_MOV   = 4'd8,
        OP_MOVI  = 4'd9,
        OP_LOAD  = 4'd10,
        OP_STORE = 4'd11,
        OP_JZ    = 4'd12,
        OP_JN    = 4'd13,
        OP_JP    = 4'd14,
        OP_HALT  = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_RS  = 2'd1,
        WB_IMM = 2'd2,
        WB_MEM = 2'd3
    } wb_sel_e;

    typedef enum logic [1:0] {
        JC_ZERO = 2'd0,
        JC_NEG  = 2'd1,
        JC_POS  = 2'd2
    } jcond_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } core_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic p;
    } flags_t;

    typedef struct packed {
        opcode_e op;
        logic    reg_form;
        logic    reg_we;
        wb_sel_e wb_sel;
        logic    flags_we;
        logic    mem_we;
        logic    addr_from_rd;
        logic    is_jump;
        jcond_e  jcond;
        logic    is_halt;
    } ctrl_t;

endpackage

// File: rtl/hv16_decode.sv
module hv16_decode
    import hv16_pkg::*;
(
    input  logic [INSTR_W-1:0]  instr,
    output ctrl_t               ctrl,
    output logic [RFIELD_W-1:0] rd,
    output logic [RFIELD_W-1:0] rs,
    output logic [IMM_W-1:0]    imm
);

    // Field positions are fixed by the instruction format.
    assign rd  = instr[11:10];
    assign rs  = instr[9:8];
    assign imm = instr[IMM_W-1:0];

    always_comb begin
        ctrl              = '0;
        ctrl.op           = opcode_e'(instr[15:12]);
        ctrl.reg_form     = (instr[IMM_W-1:0] == REG_FORM_MARK);
        ctrl.wb_sel       = WB_ALU;
        ctrl.jcond        = JC_ZERO;
        unique case (ctrl.op)
            OP_OR, OP_NOT, OP_AND, OP_XOR,
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                ctrl.reg_we   = 1'b1;
                ctrl.wb_sel   = WB_ALU;
                ctrl.flags_we = 1'b1;
            end
            OP_MOV: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_RS;
            end
            OP_MOVI: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_IMM;
            end
            OP_LOAD: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_MEM;
            end
            OP_STORE: begin
                ctrl.mem_we       = 1'b1;
                ctrl.addr_from_rd = 1'b1;
            end
            OP_JZ: begin
                ctrl.is_jump = 1'b1;
                ctrl.jcond   = JC_ZERO;
            end
            OP_JN: begin
                ctrl.is_jump = 1'b1;
                ctrl.jcond   = JC_NEG;
            end
            OP_JP: begin
                ctrl.is_jump = 1'b1;
                ctrl.jcond   = JC_POS;
            end
            OP_HALT: begin
                ctrl.is_halt = 1'b1;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hv16_alu.sv
module hv16_alu
    import hv16_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output flags_t        f
);

    logic [2*DW-1:0] prod;
    logic [DW-1:0]   quot;

    assign prod = a * b;

    // Division by zero saturates to all ones.
    always_comb begin
        if (b == '0) begin
            quot = '1;
        end else begin
            quot = a / b;
        end
    end

    always_comb begin
        unique case (op)
            OP_OR:   y = a | b;
            OP_NOT:  y = ~a;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DW-1:0];
            OP_DIV:  y = quot;
            default: y = '0;
        endcase
    end

    always_comb begin
        f.z = (y == '0);
        f.n = y[DW-1];
        f.p = !f.z && !f.n;
    end

endmodule

// File: rtl/hv16_regbank.sv
module hv16_regbank #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    output logic [DW-1:0]     rdata_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [DW-1:0]     rdata_b
);

    logic [DW-1:0] q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[gi] <= '0;
            end else if (we && (waddr == RIDX_W'(gi))) begin
                q[gi] <= wdata;
            end
        end
    end

    assign rdata_a = q[raddr_a];
    assign rdata_b = q[raddr_b];

endmodule

// File: rtl/hv16_core.sv
module hv16_core
    import hv16_pkg::*;
#(
    parameter int DW   = 16,
    parameter int PC_W = 16,
    parameter int NREG = 4
) (
    input  logic                clk,
    input  logic                rst,
    output logic [PC_W-1:0]     imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [DW-1:0]       dmem_addr,
    output logic [DW-1:0]       dmem_wdata,
    output logic                dmem_we,
    input  logic [DW-1:0]       dmem_rdata,
    output logic                halted
);

    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    core_state_e state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    flags_t          flags_q;
    flags_t          alu_flags;

    ctrl_t               ctrl;
    logic [RFIELD_W-1:0] rd_f, rs_f;
    logic [IMM_W-1:0]    imm_f;
    logic [DW-1:0]       rd_val, rs_val, operand_b, alu_y, wb_data, imm_ext;
    logic                running;
    logic                cond_ok, jump_taken;
    logic [PC_W-1:0]     jump_target;

    hv16_decode u_decode (
        .instr (imem_data),
        .ctrl  (ctrl),
        .rd    (rd_f),
        .rs    (rs_f),
        .imm   (imm_f)
    );

    hv16_regbank #(.DW(DW), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (running && ctrl.reg_we),
        .waddr   (RIDX_W'(rd_f)),
        .wdata   (wb_data),
        .raddr_a (RIDX_W'(rd_f)),
        .rdata_a (rd_val),
        .raddr_b (RIDX_W'(rs_f)),
        .rdata_b (rs_val)
    );

    assign imm_ext   = DW'(imm_f);
    assign operand_b = ctrl.reg_form ? rs_val : imm_ext;

    hv16_alu #(.DW(DW)) u_alu (
        .op (ctrl.op),
        .a  (rd_val),
        .b  (operand_b),
        .y  (alu_y),
        .f  (alu_flags)
    );

    // Write-back source select.
    always_comb begin
        unique case (ctrl.wb_sel)
            WB_ALU:  wb_data = alu_y;
            WB_RS:   wb_data = rs_val;
            WB_IMM:  wb_data = imm_ext;
            WB_MEM:  wb_data = dmem_rdata;
            default: wb_data = alu_y;
        endcase
    end

    // Jump condition and target.
    always_comb begin
        unique case (ctrl.jcond)
            JC_ZERO: cond_ok = flags_q.z;
            JC_NEG:  cond_ok = flags_q.n;
            JC_POS:  cond_ok = flags_q.p;
            default: cond_ok = 1'b0;
        endcase
        jump_taken  = running && ctrl.is_jump && cond_ok;
        jump_target = ctrl.reg_form ? PC_W'(rd_val) : PC_W'(imm_f);
    end

    // Next state of the run/halt controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl.is_halt) state_d = ST_HALT;   // halt_seen
            ST_HALT: state_d = ST_HALT;                     // hold
            default: state_d = ST_RUN;
        endcase
    end

    // State register; reset is the only way back to ST_RUN (reset_exit).
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Controller outputs.
    always_comb begin
        running = (state_q == ST_RUN);
        halted  = (state_q == ST_HALT);
        dmem_we = running && ctrl.mem_we;
    end

    // Program counter sequencing.
    always_comb begin
        if (!running || ctrl.is_halt) begin
            pc_d = pc_q;
        end else if (jump_taken) begin
            pc_d = jump_target;
        end else begin
            pc_d = pc_q + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            flags_q <= '0;
        end else begin
            pc_q <= pc_d;
            if (running && ctrl.flags_we) begin
                flags_q <= alu_flags;
            end
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = ctrl.addr_from_rd ? rd_val : rs_val;
    assign dmem_wdata = rs_val;

endmodule

// File: rtl/hv16_core_chk.sv
module hv16_core_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic [15:0]     imem_data,
    input logic            dmem_we,
    input logic            halted,
    input logic [2:0]      flags_q
);

    // R1: reset returns the core to address 0, running
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !halted));

    // R2: sequential instructions step the program counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!halted && imem_data[15:12] < 4'd12) |=> (imem_addr == $past(imem_addr) + PC_W'(1)));

    // R5: non-arithmetic instructions keep the flags
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!halted && imem_data[15:12] >= 4'd8) |=> $stable(flags_q));

    // R5: flags are one of the three exclusive conditions or clear
    assert_flags_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_q));

    // R8: only a store drives the write enable
    assert_we_store_only_R8: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_data[15:12] == 4'd11 && !halted));

    // R9: halted stays set and freezes the program counter
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(imem_addr)));

    // R9: HALT word leads to halted on the next cycle
    assert_halt_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (!halted && imem_data[15:12] == 4'd15) |=> (halted && $stable(imem_addr)));

endmodule

bind hv16_core hv16_core_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .halted    (halted),
    .flags_q   (flags_q)
);

// File: tb/hv16_core_tb_top.sv
`timescale 1ns/1ps
module hv16_core_tb_top;

    localparam logic [3:0] AX = 4'd0, BX = 4'd1, CX = 4'd2, DX = 4'd3;
    localparam logic [7:0] RF = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, imem_data;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    logic [15:0] m_pc;
    logic [15:0] m_r [4];
    logic [15:0] m_mem [256];
    bit m_z, m_n, m_p, m_h;

    always #2.5 clk = ~clk;

    hv16_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .halted     (halted)
    );

    assign imem_data  = imem[imem_addr[7:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    function automatic logic [15:0] enc(logic [3:0] op, logic [3:0] rd, logic [3:0] rs, logic [7:0] imm);
        return {op, rd[1:0], rs[1:0], imm};
    endfunction

    task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_imem();
        for (int i = 0; i < 256; i++) imem[i] = 16'hF000;
    endtask

    // Behavioural reference: one instruction per call.
    task automatic model_step();
        logic [15:0] ins, b, res;
        int op, rd, rs;
        bit rf, cond;
        ins = imem[m_pc[7:0]];
        op = int'(ins[15:12]);
        rd = int'(ins[11:10]);
        rs = int'(ins[9:8]);
        rf = (ins[7:0] == 8'hFF);
        b  = rf ? m_r[rs] : {8'h00, ins[7:0]};
        if (m_h) return;
        if (op <= 7) begin
            case (op)
                0: res = m_r[rd] | b;
                1: res = ~m_r[rd];
                2: res = m_r[rd] & b;
                3: res = m_r[rd] ^ b;
                4: res = m_r[rd] + b;
                5: res = m_r[rd] - b;
                6: res = m_r[rd] * b;
                default: res = (b == 0) ? 16'hFFFF : m_r[rd] / b;
            endcase
            m_r[rd] = res;
            m_z = (res == 0);
            m_n = res[15];
            m_p = !m_z && !m_n;
            m_pc = m_pc + 1;
        end else if (op == 8) begin
            m_r[rd] = m_r[rs]; m_pc = m_pc + 1;
        end else if (op == 9) begin
            m_r[rd] = {8'h00, ins[7:0]}; m_pc = m_pc + 1;
        end else if (op == 10) begin
            m_r[rd] = m_mem[m_r[rs][7:0]]; m_pc = m_pc + 1;
        end else if (op == 11) begin
            m_mem[m_r[rd][7:0]] = m_r[rs]; m_pc = m_pc + 1;
        end else if (op <= 14) begin
            cond = (op == 12) ? m_z : (op == 13) ? m_n : m_p;
            if (cond) m_pc = rf ? m_r[rd] : {8'h00, ins[7:0]};
            else      m_pc = m_pc + 1;
        end else begin
            m_h = 1;
        end
    endtask

    task automatic compare_cycle();
        logic [15:0] ins;
        bit exp_we;
        ins = imem[m_pc[7:0]];
        exp_we = !m_h && ins[15:12] == 4'd11;
        check(imem_addr == m_pc, "R2/R6", "pc", imem_addr, m_pc);
        check(halted == m_h, "R9", "halted", {15'd0, halted}, {15'd0, m_h});
        check(dmem_we == exp_we, "R8", "we", {15'd0, dmem_we}, {15'd0, exp_we});
        if (exp_we) begin
            check(dmem_addr == m_r[ins[11:10]], "R8", "store addr", dmem_addr, m_r[ins[11:10]]);
            check(dmem_wdata == m_r[ins[9:8]], "R8", "store data", dmem_wdata, m_r[ins[9:8]]);
        end
    endtask

    task automatic run_prog(int max_cycles);
        int cyc = 0;
        int after_halt = 0;
        rst = 1'b1;
        m_pc = 0; m_z = 0; m_n = 0; m_p = 0; m_h = 0;
        for (int i = 0; i < 4; i++) m_r[i] = 16'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 16'h0, "R1", "reset pc", imem_addr, 16'h0);
        check(halted == 1'b0, "R1", "reset halted", {15'd0, halted}, 16'h0);
        rst = 1'b0;
        while (after_halt < 4) begin
            compare_cycle();
            model_step();
            if (m_h) after_halt++;
            cyc++;
            if (cyc > max_cycles) begin
                check(0, "R10", "program watchdog", 16'(cyc), 16'(max_cycles));
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 16'h0;
            m_mem[i] = 16'h0;
        end

        // Program A: arithmetic in both operand forms
        clear_imem();
        imem[0]  = enc(4'd9, AX, AX, 8'h12);
        imem[1]  = enc(4'd9, BX, AX, 8'h34);
        imem[2]  = enc(4'd9, CX, AX, 8'h80);
        imem[3]  = enc(4'd0, AX, BX, RF);     // OR ax,bx
        imem[4]  = enc(4'd11, CX, AX, 8'h0);
        imem[5]  = enc(4'd4, CX, AX, 8'h01);
        imem[6]  = enc(4'd3, AX, AX, 8'h0F);  // XOR imm
        imem[7]  = enc(4'd11, CX, AX, 8'h0);
        imem[8]  = enc(4'd4, CX, AX, 8'h01);
        imem[9]  = enc(4'd9, DX, AX, 8'h07);
        imem[10] = enc(4'd6, DX, BX, RF);     // MULT
        imem[11] = enc(4'd11, CX, DX, 8'h0);
        imem[12] = enc(4'd4, CX, AX, 8'h01);
        imem[13] = enc(4'd9, DX, AX, 8'h00);
        imem[14] = enc(4'd9, AX, AX, 8'd100);
        imem[15] = enc(4'd7, AX, DX, RF);     // DIV by zero
        imem[16] = enc(4'd11, CX, AX, 8'h0);
        imem[17] = enc(4'd4, CX, AX, 8'h01);
        imem[18] = enc(4'd9, AX, AX, 8'd100);
        imem[19] = enc(4'd7, AX, AX, 8'd7);   // DIV imm
        imem[20] = enc(4'd11, CX, AX, 8'h0);
        imem[21] = enc(4'd4, CX, AX, 8'h01);
        imem[22] = enc(4'd1, AX, AX, 8'h00);  // NOT
        imem[23] = enc(4'd11, CX, AX, 8'h0);
        imem[24] = enc(4'd4, CX, AX, 8'h01);
        imem[25] = enc(4'd9, BX, AX, 8'h0F);
        imem[26] = enc(4'd2, AX, BX, RF);     // AND
        imem[27] = enc(4'd5, AX, AX, 8'd3);   // SUB
        imem[28] = enc(4'd11, CX, AX, 8'h0);
        run_prog(200);
        check(dmem[128] == 16'h0036, "R3", "OR reg", dmem[128], 16'h0036);
        check(dmem[129] == 16'h0039, "R3", "XOR imm", dmem[129], 16'h0039);
        check(dmem[130] == 16'h016C, "R4", "MULT", dmem[130], 16'h016C);
        check(dmem[131] == 16'hFFFF, "R4", "DIV zero", dmem[131], 16'hFFFF);
        check(dmem[132] == 16'h000E, "R4", "DIV imm", dmem[132], 16'h000E);
        check(dmem[133] == 16'hFFF1, "R3", "NOT", dmem[133], 16'hFFF1);
        check(dmem[134] == 16'hFFFE, "R3", "AND/SUB", dmem[134], 16'hFFFE);
        check(imem_addr == 16'd29, "R9", "halt pc", imem_addr, 16'd29);

        // Program B: countdown loop through memory
        clear_imem();
        imem[0]  = enc(4'd9, AX, AX, 8'h01);
        imem[1]  = enc(4'd3, BX, BX, RF);
        imem[2]  = enc(4'd9, CX, AX, 8'h40);
        imem[3]  = enc(4'd9, DX, AX, 8'h05);
        imem[4]  = enc(4'd4, AX, BX, RF);
        imem[5]  = enc(4'd11, CX, AX, 8'h0);
        imem[6]  = enc(4'd8, AX, BX, 8'h0);   // MOV
        imem[7]  = enc(4'd10, BX, CX, 8'h0);  // LOAD
        imem[8]  = enc(4'd5, DX, AX, 8'h01);
        imem[9]  = enc(4'd14, AX, AX, 8'h04); // JMPP 4
        imem[10] = enc(4'd9, CX, AX, 8'h41);
        imem[11] = enc(4'd11, CX, BX, 8'h0);
        run_prog(400);
        check(dmem[16'h41] == 16'd5, "R10", "loop result", dmem[16'h41], 16'd5);
        check(dmem[16'h40] == 16'd5, "R7", "last stored", dmem[16'h40], 16'd5);
        check(imem_addr == 16'd12, "R10", "loop exit pc", imem_addr, 16'd12);

        // Program C: flags held across non-arithmetic instructions
        clear_imem();
        imem[0]  = enc(4'd9, AX, AX, 8'h05);
        imem[1]  = enc(4'd5, AX, AX, 8'h05);   // zero
        imem[2]  = enc(4'd9, BX, AX, 8'h03);
        imem[3]  = enc(4'd9, CX, AX, 8'h50);
        imem[4]  = enc(4'd11, CX, BX, 8'h0);
        imem[5]  = enc(4'd10, DX, CX, 8'h0);
        imem[6]  = enc(4'd12, AX, AX, 8'h09);  // JMPZ 9
        imem[7]  = enc(4'd9, AX, AX, 8'hAA);
        imem[8]  = enc(4'd11, CX, AX, 8'h0);
        imem[9]  = enc(4'd9, BX, AX, 8'd15);
        imem[10] = enc(4'd13, BX, AX, RF);     // JMPN bx, not taken
        imem[11] = enc(4'd14, AX, AX, 8'd20);  // JMPP 20, not taken
        imem[12] = enc(4'd5, AX, AX, 8'h01);   // negative
        imem[13] = enc(4'd13, BX, AX, RF);     // JMPN bx -> 15
        imem[14] = enc(4'd9, AX, AX, 8'h00);
        imem[15] = enc(4'd11, CX, AX, 8'h0);
        imem[16] = enc(4'd4, CX, AX, 8'h01);
        imem[17] = enc(4'd11, CX, DX, 8'h0);
        run_prog(200);
        check(dmem[16'h50] == 16'hFFFF, "R6", "reg-target jump", dmem[16'h50], 16'hFFFF);
        check(dmem[16'h51] == 16'h0003, "R8", "load value", dmem[16'h51], 16'h0003);
        check(imem_addr == 16'd18, "R5", "flag path pc", imem_addr, 16'd18);

        // Program D: flags clear after reset
        clear_imem();
        imem[0] = enc(4'd12, AX, AX, 8'h05);
        imem[1] = enc(4'd13, AX, AX, 8'h05);
        imem[2] = enc(4'd14, AX, AX, 8'h05);
        run_prog(50);
        check(imem_addr == 16'd3, "R1", "no jump after reset", imem_addr, 16'd3);
        check(dmem[16'h50] == 16'hFFFF, "R9", "memory kept while halted", dmem[16'h50], 16'hFFFF);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule